// File: doc/BRIEF.md
# Configurable Hardware Stack Pointer Unit

This block keeps the pointer of a small hardware stack and owns the storage behind it. Two static configuration inputs choose whether the stack grows toward higher or lower addresses, and whether the pointer marks the most recently written entry ("last full") or the slot the next push will fill ("next empty"). A push or pop request starts a two-step sequence. One step moves the pointer by one entry. The other step reads or writes the storage. Their order depends on the operation and on the pointer convention, so that every mode places and retrieves data at the right slot.

The unit is meant for call/return linkage or small operand stacks next to a controller. The controller raises a one-cycle request, waits for the one-cycle completion pulse, and then takes popped data from the data output. A push onto a full stack or a pop from an empty one is refused. The refusal shows as a single-cycle error flag, and the pointer and the stored data do not change. The configuration may change only while reset is held, and reset loads the pointer with the empty value of the selected mode.

Top module: `stk_ptr_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, sp_o holds the empty value of the selected mode: up/last-full 31 (one below entry 0, 5-bit pointer), up/next-empty 0, down/last-full 16, down/next-empty 15. done_o, overflow_o and underflow_o are low. The configuration inputs stay stable while reset is high.
- R2: Growing up (cfg_down=0) with cfg_next_empty=0, a push first adds one to sp_o and then writes the data at the new pointer. A pop first reads the entry at sp_o and then subtracts one.
- R3: Growing up with cfg_next_empty=1, a push first writes at sp_o and then adds one. A pop first subtracts one and then reads at the new pointer.
- R4: Growing down (cfg_down=1) follows the same orderings as R2 and R3, with the pointer decremented on push and incremented on pop.
- R5: A request sampled at clock edge k takes effect in two steps, at edges k+1 and k+2. After edge k+1, sp_o shows the pointer of the first step. After edge k+2, done_o is high for exactly one cycle, sp_o holds the final pointer, and for a pop, pop_data_o holds the popped entry.
- R6: A push when the stack already holds 16 entries raises overflow_o for one cycle after the sampling edge. sp_o and the stored entries stay unchanged, and done_o stays low.
- R7: A pop on an empty stack raises underflow_o for one cycle after the sampling edge. sp_o stays unchanged and done_o stays low.
- R8: Push or pop requests sampled while an operation is in progress are ignored. They raise no flag and do not change the pointer or the stored data.
- R9: When push_i and pop_i are high together, the request is handled as a push.
- R10: Entries come back in reverse order of pushing, including across a complete fill to 16 entries followed by a complete drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_down | input | 1 | 1: stack grows toward lower addresses |
| cfg_next_empty | input | 1 | 1: pointer marks the next free slot; 0: pointer marks the last written entry |
| push_i | input | 1 | Push request, one cycle |
| pop_i | input | 1 | Pop request, one cycle |
| push_data_i | input | 32 | Data to push, sampled with the request |
| pop_data_o | output | 32 | Popped data, valid with done_o after a pop |
| done_o | output | 1 | One-cycle completion pulse |
| overflow_o | output | 1 | One-cycle pulse: push refused, stack full |
| underflow_o | output | 1 | One-cycle pulse: pop refused, stack empty |
| sp_o | output | 5 | Current stack pointer |

## Verification
The hardest situation to reach is a request that arrives while an operation is still in its middle steps, at a moment when the same request would be refused or accepted if the unit were idle. The bench therefore drives random push and pop requests on both busy cycles of every operation. It also fills the stack to its limit and then drains it in each of the four modes, so these stray requests land at the full and empty boundaries. Afterwards it confirms, through the pointer, the flags and the data popped later, that none of them had any effect.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_bounds.sv
module stk_bounds #(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input  logic          cfg_down,
    input  logic          cfg_next_empty,
    output logic [PW-1:0] empty_ptr,
    output logic [PW-1:0] full_ptr,
    output logic [PW-1:0] push_delta
);
    localparam logic [PW-1:0] TOP = PW'(DEPTH - 1);
    localparam logic [PW-1:0] END = PW'(DEPTH);

    always_comb begin
        unique case ({cfg_down, cfg_next_empty})
            2'b00: begin empty_ptr = '1;      full_ptr = TOP; end
            2'b01: begin empty_ptr = '0;      full_ptr = END; end
            2'b10: begin empty_ptr = END;     full_ptr = '0;  end
            default: begin empty_ptr = TOP;   full_ptr = '1;  end
        endcase
        push_delta = cfg_down ? '1 : PW'(1);
    end
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
        if (re) rdata_q <= mem_q[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_down,
    input  logic             cfg_next_empty,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] pop_data_o,
    output logic             done_o,
    output logic             overflow_o,
    output logic             underflow_o,
    output logic [PW-1:0]    sp_o
);
    import stk_pkg::*;

    typedef struct packed {
        stk_state_e       st;
        logic             op_push;
        logic [WIDTH-1:0] wbuf;
        logic [PW-1:0]    sp;
        logic             done;
        logic             ovf;
        logic             unf;
    } regs_t;

    regs_t r_q, r_d;

    logic [PW-1:0] empty_ptr, full_ptr, push_delta, step;
    logic          access_first, mem_we, mem_re;

    stk_bounds #(.DEPTH(DEPTH), .PW(PW)) u_bounds (
        .cfg_down       (cfg_down),
        .cfg_next_empty (cfg_next_empty),
        .empty_ptr      (empty_ptr),
        .full_ptr       (full_ptr),
        .push_delta     (push_delta)
    );

    stk_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (r_q.sp[AW-1:0]),
        .wdata (r_q.wbuf),
        .rdata (pop_data_o)
    );

    // Push in next-empty mode and pop in last-full mode touch memory before moving.
    assign access_first = r_q.op_push ? cfg_next_empty : !cfg_next_empty;
    assign step         = r_q.op_push ? push_delta : (PW'(0) - push_delta);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.ovf  = 1'b0;
        r_d.unf  = 1'b0;
        mem_we   = 1'b0;
        mem_re   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (push_i) begin
                    if (r_q.sp == full_ptr) begin
                        r_d.ovf = 1'b1;
                    end else begin
                        r_d.st      = ST_FIRST;
                        r_d.op_push = 1'b1;
                        r_d.wbuf    = push_data_i;
                    end
                end else if (pop_i) begin
                    if (r_q.sp == empty_ptr) begin
                        r_d.unf = 1'b1;
                    end else begin
                        r_d.st      = ST_FIRST;
                        r_d.op_push = 1'b0;
                    end
                end
            end
            ST_FIRST: begin
                if (access_first) begin
                    mem_we = r_q.op_push;
                    mem_re = !r_q.op_push;
                end else begin
                    r_d.sp = r_q.sp + step;
                end
                r_d.st = ST_SECOND;
            end
            default: begin
                if (access_first) begin
                    r_d.sp = r_q.sp + step;
                end else begin
                    mem_we = r_q.op_push;
                    mem_re = !r_q.op_push;
                end
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
        endcase
        if (!rst_n) begin
            r_d = '{st: ST_IDLE, op_push: 1'b0, wbuf: '0, sp: empty_ptr,
                    done: 1'b0, ovf: 1'b0, unf: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign done_o      = r_q.done;
    assign overflow_o  = r_q.ovf;
    assign underflow_o = r_q.unf;
    assign sp_o        = r_q.sp;

    // R1
    cfg_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(cfg_down) && $stable(cfg_next_empty)));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && push_i && sp_o == full_ptr)
        |=> (overflow_o && !done_o && sp_o == $past(sp_o)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !push_i && pop_i && sp_o == empty_ptr)
        |=> (underflow_o && !done_o && sp_o == $past(sp_o)));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> (!overflow_o && !underflow_o));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !push_i && !pop_i) |=> $stable(sp_o));
endmodule

// File: tb/sim_stk_ptr_unit.sv
`timescale 1ns/1ps
module sim_stk_ptr_unit;
    localparam int DEPTH = 16;
    localparam int WIDTH = 32;
    localparam int PW    = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_down = 1'b0;
    logic             cfg_next_empty = 1'b0;
    logic             push_i = 1'b0;
    logic             pop_i = 1'b0;
    logic [WIDTH-1:0] push_data_i = '0;
    logic [WIDTH-1:0] pop_data_o;
    logic             done_o, overflow_o, underflow_o;
    logic [PW-1:0]    sp_o;

    always #4 clk = ~clk;

    stk_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_down(cfg_down), .cfg_next_empty(cfg_next_empty),
        .push_i(push_i), .pop_i(pop_i), .push_data_i(push_data_i),
        .pop_data_o(pop_data_o), .done_o(done_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .sp_o(sp_o)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] model [DEPTH];
    int          cnt = 0;
    string       mtag = "R2";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] exp_sp(input int c);
        int v;
        if (!cfg_down) v = cfg_next_empty ? c : c - 1;
        else           v = cfg_next_empty ? DEPTH - 1 - c : DEPTH - c;
        return PW'(v);
    endfunction

    task automatic set_mode(input bit down, input bit ne);
        @(negedge clk);
        rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        cfg_down = down; cfg_next_empty = ne;
        mtag = down ? "R4" : (ne ? "R3" : "R2");
        repeat (3) @(negedge clk);
        chk(sp_o == exp_sp(0), "R1", "sp in reset", 32'(sp_o), 32'(exp_sp(0)));
        rst_n = 1'b1;
        cnt = 0;
        @(negedge clk);
        chk(sp_o == exp_sp(0), "R1", "sp after reset", 32'(sp_o), 32'(exp_sp(0)));
        chk(!done_o && !overflow_o && !underflow_o, "R1", "flags after reset",
            {29'd0, done_o, overflow_o, underflow_o}, 32'd0);
    endtask

    task automatic op(input bit p, input bit q, input logic [31:0] d, input string tag_in);
        bit eff_push, eff_pop, upd_first;
        logic [PW-1:0] old_sp, new_sp, mid_sp;
        string tg;
        eff_push = p;
        eff_pop  = !p && q;
        tg = (tag_in != "") ? tag_in : ((p && q) ? "R9" : mtag);
        old_sp = exp_sp(cnt);
        @(negedge clk);
        push_i = p; pop_i = q; push_data_i = d;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        if (eff_push && cnt == DEPTH) begin
            chk(overflow_o && !done_o, "R6", "overflow flag", {30'd0, overflow_o, done_o}, 32'd2);
            chk(sp_o == old_sp, "R6", "sp on overflow", 32'(sp_o), 32'(old_sp));
            return;
        end
        if (eff_pop && cnt == 0) begin
            chk(underflow_o && !done_o, "R7", "underflow flag", {30'd0, underflow_o, done_o}, 32'd2);
            chk(sp_o == old_sp, "R7", "sp on underflow", 32'(sp_o), 32'(old_sp));
            return;
        end
        if (!eff_push && !eff_pop) begin
            chk(sp_o == old_sp, "R5", "sp idle", 32'(sp_o), 32'(old_sp));
            return;
        end
        new_sp    = exp_sp(eff_push ? cnt + 1 : cnt - 1);
        upd_first = eff_push ? !cfg_next_empty : cfg_next_empty;
        mid_sp    = upd_first ? new_sp : old_sp;
        chk(sp_o == old_sp, "R5", "sp before first step", 32'(sp_o), 32'(old_sp));
        push_i = 1'($urandom); pop_i = 1'($urandom); push_data_i = $urandom;
        @(negedge clk);
        chk(sp_o == mid_sp, tg, "sp after first step", 32'(sp_o), 32'(mid_sp));
        chk(!overflow_o && !underflow_o && !done_o, "R8", "flags mid op",
            {29'd0, overflow_o, underflow_o, done_o}, 32'd0);
        push_i = 1'($urandom); pop_i = 1'($urandom); push_data_i = $urandom;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0;
        chk(done_o, "R5", "done pulse", 32'(done_o), 32'd1);
        chk(!overflow_o && !underflow_o, "R8", "no flag from busy request",
            {30'd0, overflow_o, underflow_o}, 32'd0);
        chk(sp_o == new_sp, tg, "final sp", 32'(sp_o), 32'(new_sp));
        if (eff_push) begin
            model[cnt] = d;
            cnt++;
        end else begin
            cnt--;
            chk(pop_data_o == model[cnt], tg, "popped data", pop_data_o, model[cnt]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            op(1'b0, 1'b1, 32'h0, "");
            for (int i = 0; i < DEPTH; i++) op(1'b1, 1'b0, $urandom, "");
            op(1'b1, 1'b0, 32'hDEAD_BEEF, "");
            op(1'b1, 1'b1, 32'hFEED_F00D, "R9");
            for (int i = 0; i < DEPTH; i++) op(1'b0, 1'b1, 32'h0, "R10");
            op(1'b0, 1'b1, 32'h0, "");
            op(1'b1, 1'b1, 32'hA5A5_0001, "R9");
            for (int i = 0; i < 150; i++) begin
                int sel;
                sel = int'($urandom % 8);
                op(sel < 4, sel >= 3 && sel < 7, $urandom, "");
            end
            while (cnt > 0) op(1'b0, 1'b1, 32'h0, "R10");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule